// File: doc/BRIEF.md
# Dual-Channel Parallel Load Register

This block takes writes from a shared 12-bit parallel bus and keeps a word for each of two output channels. One active-low write strobe is shared. Each channel has its own active-low select. All three strobes are asynchronous to the system clock. Each passes through a synchroniser before any edge is detected. The data bus goes through a delay line of the same length, so a captured word stays aligned with the strobe sample that triggered it.

A channel captures when the OR of its select and the write strobe goes from low to high. This means the capture happens on whichever of the two signals releases last. Holding the strobes low never loads anything. While the write strobe stays high, or while a channel's select stays high, that channel cannot load. A single rising edge can load both channels with the same word. Each capture produces a one-clock update pulse on its channel. Downstream logic therefore sees every write, even when the new word equals the old one.

Top module: `dual_load_reg`

## Requirements
- R1: While rst_ni is low and after it is released with strobes idle high, q_a_o and q_b_o read 0 and upd_a_o and upd_b_o stay low.
- R2: With cs_a_ni low and cs_b_ni high, a low-to-high transition of wr_ni loads data_i into channel A only.
- R3: With cs_b_ni low and cs_a_ni high, a low-to-high transition of wr_ni loads data_i into channel B only.
- R4: With both selects low, a rising wr_ni loads the same data_i word into both channels.
- R5: With wr_ni held low, a rising cs_a_ni loads channel A, a rising cs_b_ni loads channel B, and both rising in the same cycle load both channels.
- R6: While wr_ni stays high, toggling the selects changes neither held word and raises no update pulse.
- R7: While both selects stay high, toggling wr_ni changes neither held word and raises no update pulse.
- R8: While a channel's select and wr_ni are both held low, changes on data_i do not reach that channel's held word.
- R9: The captured word is the data_i value sampled on the same clock edge as the first high sample of the releasing strobe. The held word and the update pulse appear after the third rising clock edge counted from that sampling edge (the sampling edge being the first).
- R10: Each capture raises that channel's update pulse for exactly one clock, including when the word written equals the stored one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_a_ni | input | 1 | Channel A select, active low, asynchronous |
| cs_b_ni | input | 1 | Channel B select, active low, asynchronous |
| wr_ni | input | 1 | Shared write strobe, active low, asynchronous |
| data_i | input | 12 | Shared parallel data bus |
| q_a_o | output | 12 | Channel A held word |
| q_b_o | output | 12 | Channel B held word |
| upd_a_o | output | 1 | Channel A one-clock update pulse |
| upd_b_o | output | 1 | Channel B one-clock update pulse |

## Verification
The main function is tried with three kinds of write. In the first, the write strobe releases last with one select low or both low; this separates the single-channel paths from the broadcast path. In the second, the selects release last while the write strobe is held low, which shows that a select acts as an edge source and not as a plain enable. In the third, one strobe toggles while the other stays high; this must produce no capture. Changing the bus while the strobes are held low, and changing it on the cycle right after the release, shows that the word is taken at the release and not at the level. A repeated identical write shows that the update pulse does not depend on whether the value changed.

// File: rtl/dual_load_pkg.sv
package dual_load_pkg;
  localparam int unsigned N_CH = 2;
  typedef enum logic [0:0] {CH_A = 1'b0, CH_B = 1'b1} ch_e;
endpackage

// File: rtl/dly_line.sv
module dly_line #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= RST_VAL;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/edge_qual.sv
module edge_qual #(
  parameter int unsigned N_CH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] cs_n_i,
  input  logic            wr_n_i,
  output logic [N_CH-1:0] cap_o
);
  logic [N_CH-1:0] sel_n;
  logic [N_CH-1:0] sel_n_q;

  // channel idle unless both its select and the strobe are low
  assign sel_n = cs_n_i | {N_CH{wr_n_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_n_q <= '1;
    else         sel_n_q <= sel_n;
  end

  // last releasing strobe fires the capture
  assign cap_o = sel_n & ~sel_n_q;

  // R6
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_n_i && $past(wr_n_i)) |-> (cap_o == '0));

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    // R7
    cs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cs_n_i[c] && $past(cs_n_i[c])) |-> !cap_o[c]);
  end
endmodule

// File: rtl/hold_reg.sv
module hold_reg #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic             upd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= '0;
      upd_o <= 1'b0;
    end else begin
      upd_o <= cap_i;
      if (cap_i) q_o <= d_i;
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(q_o));

  // R9
  load_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (q_o == $past(d_i)));

  // R10
  upd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o);
endmodule

// File: rtl/dual_load_reg.sv
module dual_load_reg #(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_a_ni,
  input  logic              cs_b_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] q_a_o,
  output logic [DATA_W-1:0] q_b_o,
  output logic              upd_a_o,
  output logic              upd_b_o
);
  import dual_load_pkg::*;

  localparam int unsigned STB_W = N_CH + 1;

  logic [STB_W-1:0]  stb_raw, stb_s;
  logic [DATA_W-1:0] data_s;
  logic [N_CH-1:0]   cap;
  logic [DATA_W-1:0] q   [N_CH];
  logic [N_CH-1:0]   upd;

  assign stb_raw = {wr_ni, cs_b_ni, cs_a_ni};

  // strobes idle high out of reset so release makes no edge
  dly_line #(.WIDTH(STB_W), .STAGES(SYNC_STAGES), .RST_VAL({STB_W{1'b1}})) u_stb_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(stb_raw), .q_o(stb_s)
  );

  // bus delayed to match the strobe synchroniser
  dly_line #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_dly (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(data_i), .q_o(data_s)
  );

  edge_qual #(.N_CH(N_CH)) u_edge (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .cs_n_i(stb_s[N_CH-1:0]), .wr_n_i(stb_s[N_CH]),
    .cap_o (cap)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    hold_reg #(.WIDTH(DATA_W)) u_hold (
      .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap[c]), .d_i(data_s),
      .q_o  (q[c]),  .upd_o (upd[c])
    );
  end

  assign q_a_o   = q[CH_A];
  assign q_b_o   = q[CH_B];
  assign upd_a_o = upd[CH_A];
  assign upd_b_o = upd[CH_B];

  // R1
  rst_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (q_a_o == '0 && q_b_o == '0 && !upd_a_o && !upd_b_o));
endmodule

// File: tb/sim_dual_load_reg.sv
module sim_dual_load_reg;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic clk = 0, rst_n = 0;
  logic cs_a = 1, cs_b = 1, wr = 1;
  logic [W-1:0] data = '0;
  logic [W-1:0] q_a, q_b;
  logic upd_a, upd_b;

  int checks = 0, errors = 0;
  int cnt_a = 0, cnt_b = 0;
  bit done = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_load_reg u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_a_ni(cs_a), .cs_b_ni(cs_b), .wr_ni(wr),
    .data_i(data), .q_a_o(q_a), .q_b_o(q_b), .upd_a_o(upd_a), .upd_b_o(upd_b)
  );

  // behavioural reference: history of samples, newest at index 0
  logic         h_ca [$], h_cb [$], h_wr [$];
  logic [W-1:0] h_d  [$];
  logic [W-1:0] e_qa = '0, e_qb = '0;
  logic         e_ua = 0, e_ub = 0;

  task automatic hist_fill();
    h_ca = '{1, 1, 1, 1}; h_cb = '{1, 1, 1, 1}; h_wr = '{1, 1, 1, 1};
    h_d  = '{0, 0, 0, 0};
  endtask

  initial hist_fill();

  always @(posedge clk) begin
    if (!rst_n) begin
      hist_fill();
      e_qa = '0; e_qb = '0; e_ua = 0; e_ub = 0;
    end else begin
      h_ca.push_front(cs_a); void'(h_ca.pop_back());
      h_cb.push_front(cs_b); void'(h_cb.pop_back());
      h_wr.push_front(wr);   void'(h_wr.pop_back());
      h_d.push_front(data);  void'(h_d.pop_back());
      e_ua = (h_ca[2] | h_wr[2]) && !(h_ca[3] | h_wr[3]);
      e_ub = (h_cb[2] | h_wr[2]) && !(h_cb[3] | h_wr[3]);
      if (e_ua) e_qa = h_d[2];
      if (e_ub) e_qb = h_d[2];
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "q_a", q_a, e_qa);
      chk(cur_req, "q_b", q_b, e_qb);
      chk(cur_req, "upd_a", upd_a, e_ua);
      chk(cur_req, "upd_b", upd_b, e_ub);
      if (upd_a) cnt_a++;
      if (upd_b) cnt_b++;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // write strobe releases last
  task automatic wr_write(logic ca, logic cb, logic [W-1:0] d);
    data = d; cs_a = ca; cs_b = cb; cyc(2);
    wr = 0; cyc(3);
    wr = 1; cyc(2);
    cs_a = 1; cs_b = 1; cyc(5);
  endtask

  // selects release last, write strobe held low
  task automatic cs_write(logic ra, logic rb, logic [W-1:0] d);
    data = d; wr = 0; cs_a = !ra; cs_b = !rb; cyc(3);
    cs_a = 1; cs_b = 1; cyc(2);
    wr = 1; cyc(5);
  endtask

  task automatic end_sim();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    end_sim();
  end

  initial begin
    int a0, b0;
    cyc(3);
    // R1: reset state
    chk("R1", "q_a in reset", q_a, 0);
    chk("R1", "upd_a in reset", upd_a, 0);
    rst_n = 1; cyc(4);
    chk("R1", "q_b after reset", q_b, 0);
    chk("R1", "upd_b after reset", upd_b, 0);

    cur_req = "R2"; wr_write(0, 1, 12'hA5C);
    chk("R2", "q_a", q_a, 12'hA5C); chk("R2", "q_b untouched", q_b, 0);

    cur_req = "R3"; wr_write(1, 0, 12'h3C1);
    chk("R3", "q_b", q_b, 12'h3C1); chk("R3", "q_a untouched", q_a, 12'hA5C);

    cur_req = "R4"; wr_write(0, 0, 12'h7E2);
    chk("R4", "q_a", q_a, 12'h7E2); chk("R4", "q_b", q_b, 12'h7E2);

    cur_req = "R5"; cs_write(1, 0, 12'h111);
    chk("R5", "q_a cs edge", q_a, 12'h111); chk("R5", "q_b kept", q_b, 12'h7E2);
    cs_write(0, 1, 12'h222);
    chk("R5", "q_b cs edge", q_b, 12'h222); chk("R5", "q_a kept", q_a, 12'h111);
    cs_write(1, 1, 12'hFFF);
    chk("R5", "q_a both", q_a, 12'hFFF); chk("R5", "q_b both", q_b, 12'hFFF);

    cur_req = "R6"; a0 = cnt_a; b0 = cnt_b;
    wr = 1;
    for (int i = 0; i < 4; i++) begin
      data = W'(i * 37); cs_a = 0; cs_b = i[0]; cyc(3);
      cs_a = 1; cs_b = 1; cyc(3);
    end
    cyc(4);
    chk("R6", "q_a", q_a, 12'hFFF); chk("R6", "q_b", q_b, 12'hFFF);
    chk("R6", "pulses", (cnt_a - a0) + (cnt_b - b0), 0);

    cur_req = "R7"; a0 = cnt_a; b0 = cnt_b;
    for (int i = 0; i < 4; i++) begin
      data = W'(100 + i); wr = 0; cyc(3); wr = 1; cyc(3);
    end
    cyc(4);
    chk("R7", "q_a", q_a, 12'hFFF); chk("R7", "q_b", q_b, 12'hFFF);
    chk("R7", "pulses", (cnt_a - a0) + (cnt_b - b0), 0);

    cur_req = "R8"; a0 = cnt_a;
    cs_a = 0; wr = 0;
    for (int i = 0; i < 5; i++) begin
      data = W'(12'h400 + i); cyc(2);
    end
    chk("R8", "q_a while low", q_a, 12'hFFF);
    chk("R8", "pulses while low", cnt_a - a0, 0);

    cur_req = "R9";
    data = 12'h5A5; wr = 1; cyc(1);
    data = 12'h0F0; cyc(1);
    cs_a = 1; cyc(6);
    chk("R9", "q_a word at release", q_a, 12'h5A5);

    // R9 latency: pulse after third edge counting the sampling edge
    data = 12'h6B6; cs_b = 0; wr = 0; cyc(3);
    wr = 1; cyc(2);
    chk("R9", "upd_b too early", upd_b, 0);
    cyc(1);
    chk("R9", "upd_b on time", upd_b, 1);
    chk("R9", "q_b on time", q_b, 12'h6B6);
    cs_b = 1; cyc(4);

    cur_req = "R10"; b0 = cnt_b;
    wr_write(1, 0, 12'h6B6);
    chk("R10", "same-value pulse count", cnt_b - b0, 1);
    chk("R10", "q_b same value", q_b, 12'h6B6);

    cyc(2);
    end_sim();
  end
endmodule